// File: doc/BRIEF.md
# Three-Stage Serial Character Buffer

This block is the receive-side elastic store between a slow asynchronous character line and a faster display write path. Characters arrive one bit per baud interval and are assembled in a first 7-bit shift stage. Each finished character then moves forward through two more 7-bit shift stages. A move between stages is a short serial burst: seven pulses of a much faster internal shift strobe clock the source and the destination together, so the code streams bit by bit from one register into the next.

The last stage offers its code on a valid/ready style output. The downstream side raises `slotReady` when its insertion slot (the cursor position) comes around, and that takes the held code. While the later stages wait, the first stage can already take in the next character. A start bit that arrives while the first stage is still occupied drops the new character and flags an overrun. A missing stop bit flags a framing error.

The whole block runs on one clock. Two single-cycle enable strobes set its two rates: `bitTick` marks the sampling point of each line bit, and `fastTick` is the internal shift strobe, nominally 64 times as frequent.

Top module: `serial_char_buffer`

## Requirements
- R1: The block holds up to three characters in three 7-bit stages. Characters enter only the first stage, leave only from the last stage, and are delivered in arrival order.
- R2: The line idles high. A low sample on `bitTick` while idle is a start bit. The next seven `bitTick` samples are data bits, least significant first, so the first data sample becomes bit 0 of the code. The eighth sample is a pad bit and the ninth is the stop bit, which completes a 10-bit frame.
- R3: The pad bit has no effect on the stored code.
- R4: A hop from stage k to stage k+1 starts only when stage k is full and stage k+1 is empty. It shifts on exactly seven `fastTick` strobes, and at the seventh strobe it marks the source empty and the destination full in the same clock.
- R5: The first stage accepts a new character from the line while the later stages hold or move earlier characters.
- R6: `codeValid` is high exactly while the last stage is full. While `codeValid` is high and `slotReady` is low, `entryCode` stays stable. A clock with both high takes the code, and `codeValid` is low in the next cycle.
- R7: A start bit seen while the first stage is full raises `overrun` for one cycle, in the cycle after that sample. That character is discarded, and the characters already held are unaffected.
- R8: A low stop-bit sample raises `frameErr` for one cycle, in the cycle after that sample. The character is still kept.
- R9: After reset all stages are empty, and `codeValid`, `overrun` and `frameErr` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitTick | input | 1 | One-cycle strobe at the centre of each line bit |
| fastTick | input | 1 | One-cycle internal stage-shift strobe |
| rxLine | input | 1 | Serial receive line, idle high |
| slotReady | input | 1 | Downstream insertion slot is present; takes the held code |
| codeValid | output | 1 | Last stage holds a character |
| entryCode | output | 7 | Code held in the last stage |
| overrun | output | 1 | One-cycle pulse: character dropped, first stage full |
| frameErr | output | 1 | One-cycle pulse: stop bit sampled low |

## Verification
The hardest condition to reach from the ports is an overrun. It needs every stage occupied while a fourth start bit arrives, and the only way to build that state is to keep `slotReady` low for three whole frames. The bench does exactly that, checks that the oldest code waits unchanged at the output, sends a fourth frame, and then opens the slot to confirm that only the first three codes come out, in order. A behavioural model of the frame sampler, the hop timing and the flags is compared with the outputs on every clock, so the exact cycle in which each hop completes is also checked.

// File: rtl/scb_pkg.sv
package scb_pkg;
  localparam int CHAR_BITS   = 7;
  localparam int STAGE_COUNT = 3;
  localparam int FRAME_BITS  = 10;
  localparam int HOP_COUNT   = STAGE_COUNT - 1;
  localparam int STOP_POS    = FRAME_BITS - 2;
  localparam int PHASE_W     = $clog2(FRAME_BITS);
  localparam int PULSE_W     = $clog2(CHAR_BITS + 1);

  typedef logic [CHAR_BITS-1:0] char_t;

  typedef struct packed {
    logic                 rxShift;
    logic                 rxBit;
    logic [HOP_COUNT-1:0] hopShift;
  } strobe_t;
endpackage

// File: rtl/scb_control.sv
module scb_control
  import scb_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   bitTick,
  input  logic                   fastTick,
  input  logic                   rxLine,
  input  logic                   slotReady,
  output strobe_t                strobes,
  output logic [STAGE_COUNT-1:0] fullQ,
  output logic                   overrunQ,
  output logic                   frameErrQ
);
  localparam logic [PHASE_W-1:0] LAST_DATA  = PHASE_W'(CHAR_BITS - 1);
  localparam logic [PHASE_W-1:0] STOP_AT    = PHASE_W'(STOP_POS);
  localparam logic [PULSE_W-1:0] LAST_PULSE = PULSE_W'(CHAR_BITS - 1);

  logic               rxBusy;
  logic               rxDrop;
  logic [PHASE_W-1:0] rxPhase;
  logic               rxDataPhase;
  logic               rxDone;
  logic [HOP_COUNT-1:0] hopActive;
  logic [HOP_COUNT-1:0] hopDone;

  // Line sampler: start detect, data phase, pad, stop
  assign rxDataPhase = rxBusy && !rxDrop && (rxPhase <= LAST_DATA);
  assign rxDone      = bitTick && rxDataPhase && (rxPhase == LAST_DATA);

  always_comb begin
    strobes.rxShift  = bitTick && rxDataPhase;
    strobes.rxBit    = rxLine;
    strobes.hopShift = hopActive & {HOP_COUNT{fastTick}};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxBusy    <= 1'b0;
      rxDrop    <= 1'b0;
      rxPhase   <= '0;
      overrunQ  <= 1'b0;
      frameErrQ <= 1'b0;
    end else begin
      overrunQ  <= 1'b0;
      frameErrQ <= 1'b0;
      if (bitTick) begin
        if (!rxBusy) begin
          if (!rxLine) begin
            rxBusy   <= 1'b1;
            rxPhase  <= '0;
            rxDrop   <= fullQ[0];
            overrunQ <= fullQ[0];
          end
        end else if (rxPhase == STOP_AT) begin
          rxBusy    <= 1'b0;
          frameErrQ <= !rxLine;
        end else begin
          rxPhase <= rxPhase + 1'b1;
        end
      end
    end
  end

  // R7: an overrun pulse only follows a start bit seen with the head stage full
  a_r7_overrun_needs_full: assert property (@(posedge clk) disable iff (!rstN)
    overrunQ |-> ($past(fullQ[0]) && $past(bitTick) && !$past(rxLine)));

  // R8: a framing pulse only follows a low sample on a bit strobe
  a_r8_frame_low_stop: assert property (@(posedge clk) disable iff (!rstN)
    frameErrQ |-> ($past(bitTick) && !$past(rxLine) && $past(rxBusy)));

  // Hop sequencers, one per stage boundary
  for (genvar h = 0; h < HOP_COUNT; h++) begin : gHop
    logic               active;
    logic               startHop;
    logic [PULSE_W-1:0] pulseCnt;

    assign startHop     = !active && fullQ[h] && !fullQ[h+1];
    assign hopActive[h] = active;
    assign hopDone[h]   = active && fastTick && (pulseCnt == LAST_PULSE);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        active   <= 1'b0;
        pulseCnt <= '0;
      end else if (startHop) begin
        active   <= 1'b1;
        pulseCnt <= '0;
      end else if (active && fastTick) begin
        if (pulseCnt == LAST_PULSE) begin
          active <= 1'b0;
        end else begin
          pulseCnt <= pulseCnt + 1'b1;
        end
      end
    end

    // R4: a running hop always has a full source and an empty destination
    a_r4_hop_gate: assert property (@(posedge clk) disable iff (!rstN)
      active |-> (fullQ[h] && !fullQ[h+1]));

    // R4: the destination fills in the same clock as the source empties
    a_r4_hop_handover: assert property (@(posedge clk) disable iff (!rstN)
      $rose(fullQ[h+1]) |-> $fell(fullQ[h]));
  end

  // Occupancy flags
  for (genvar s = 0; s < STAGE_COUNT; s++) begin : gFlag
    logic flag;
    logic setFlag;
    logic clrFlag;

    if (s == 0) begin : gHead
      assign setFlag = rxDone;
    end else begin : gInner
      assign setFlag = hopDone[s-1];
    end

    if (s == STAGE_COUNT - 1) begin : gTail
      assign clrFlag = flag && slotReady;
    end else begin : gPass
      assign clrFlag = hopDone[s];
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        flag <= 1'b0;
      end else if (setFlag) begin
        flag <= 1'b1;
      end else if (clrFlag) begin
        flag <= 1'b0;
      end
    end

    assign fullQ[s] = flag;
  end

  // R6: the tail only empties when the downstream slot took it
  a_r6_take_needs_slot: assert property (@(posedge clk) disable iff (!rstN)
    $fell(fullQ[STAGE_COUNT-1]) |-> $past(slotReady));
endmodule

// File: rtl/scb_datapath.sv
module scb_datapath
  import scb_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  strobe_t strobes,
  output char_t   headCode
);
  char_t stageQ [STAGE_COUNT];

  for (genvar s = 0; s < STAGE_COUNT; s++) begin : gStage
    char_t q;
    logic  load;
    logic  inBit;

    if (s == 0) begin : gEntry
      assign load  = strobes.rxShift || strobes.hopShift[0];
      assign inBit = strobes.rxShift ? strobes.rxBit : 1'b0;
    end else if (s == STAGE_COUNT - 1) begin : gExit
      assign load  = strobes.hopShift[s-1];
      assign inBit = stageQ[s-1][0];
    end else begin : gMid
      assign load  = strobes.hopShift[s-1] || strobes.hopShift[s];
      assign inBit = strobes.hopShift[s-1] ? stageQ[s-1][0] : 1'b0;
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        q <= '0;
      end else if (load) begin
        q <= {inBit, q[CHAR_BITS-1:1]};
      end
    end

    assign stageQ[s] = q;
  end

  assign headCode = stageQ[STAGE_COUNT-1];

  // R5: line capture never collides with a burst out of the entry stage
  a_r5_entry_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.rxShift && strobes.hopShift[0]));

  for (genvar h = 0; h + 1 < HOP_COUNT; h++) begin : gNoClash
    // R4: adjacent hops never share a stage in the same cycle
    a_r4_adjacent_exclusive: assert property (@(posedge clk) disable iff (!rstN)
      !(strobes.hopShift[h] && strobes.hopShift[h+1]));
  end
endmodule

// File: rtl/serial_char_buffer.sv
module serial_char_buffer
  import scb_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 bitTick,
  input  logic                 fastTick,
  input  logic                 rxLine,
  input  logic                 slotReady,
  output logic                 codeValid,
  output logic [CHAR_BITS-1:0] entryCode,
  output logic                 overrun,
  output logic                 frameErr
);
  strobe_t                strobes;
  logic [STAGE_COUNT-1:0] fullQ;
  char_t                  headCode;

  scb_control uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .bitTick   (bitTick),
    .fastTick  (fastTick),
    .rxLine    (rxLine),
    .slotReady (slotReady),
    .strobes   (strobes),
    .fullQ     (fullQ),
    .overrunQ  (overrun),
    .frameErrQ (frameErr)
  );

  scb_datapath uData (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .headCode (headCode)
  );

  assign codeValid = fullQ[STAGE_COUNT-1];
  assign entryCode = headCode;

  // R6: a code waiting for its slot does not change
  a_r6_hold_stable: assert property (@(posedge clk) disable iff (!rstN)
    (codeValid && !slotReady) |=> $stable(entryCode));

  // R9: nothing is pending or flagged in the first cycle after reset
  a_r9_reset_clean: assert property (@(posedge clk)
    !$past(rstN) |-> (!codeValid && !overrun && !frameErr));
endmodule

// File: tb/serial_char_buffer_test.sv
module serial_char_buffer_test;
  localparam int CLK_PERIOD = 10;
  localparam int FAST_DIV   = 2;
  localparam int BIT_DIV    = 128;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       bitTick = 1'b0;
  logic       fastTick = 1'b0;
  logic       rxLine = 1'b1;
  logic       slotReady = 1'b1;
  logic       codeValid;
  logic [6:0] entryCode;
  logic       overrun;
  logic       frameErr;

  int checks = 0;
  int errors = 0;
  int tickCnt = 0;
  int cycles = 0;
  bit finished = 1'b0;
  bit ovrSeen = 1'b0;
  bit ferrSeen = 1'b0;
  int gotQ[$];
  int expQ[$];

  // reference model state
  bit [2:0] mFull;
  bit [2:0] mFullOld;
  int       mVal[3];
  bit       mRun[2];
  int       mCnt[2];
  bit       mBusy;
  bit       mDrop;
  int       mPhase;
  int       mAcc;
  bit       mOvr;
  bit       mFerr;

  serial_char_buffer uut (
    .clk       (clk),
    .rstN      (rstN),
    .bitTick   (bitTick),
    .fastTick  (fastTick),
    .rxLine    (rxLine),
    .slotReady (slotReady),
    .codeValid (codeValid),
    .entryCode (entryCode),
    .overrun   (overrun),
    .frameErr  (frameErr)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(negedge clk) begin
    tickCnt  = tickCnt + 1;
    fastTick = (tickCnt % FAST_DIV) == 0;
    bitTick  = (tickCnt % BIT_DIV) == 0;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural model, advanced on every rising edge
  always @(posedge clk) begin
    if (!rstN) begin
      mFull = '0;
      for (int i = 0; i < 3; i++) mVal[i] = 0;
      for (int i = 0; i < 2; i++) begin mRun[i] = 0; mCnt[i] = 0; end
      mBusy = 0; mDrop = 0; mPhase = 0; mAcc = 0; mOvr = 0; mFerr = 0;
    end else begin
      if (codeValid && slotReady) gotQ.push_back(int'(entryCode));
      mFullOld = mFull;
      mOvr = 0;
      mFerr = 0;
      if (mFullOld[2] && slotReady) mFull[2] = 0;
      for (int h = 0; h < 2; h++) begin
        if (mRun[h]) begin
          if (fastTick) begin
            mCnt[h]++;
            if (mCnt[h] == 7) begin
              mVal[h+1] = mVal[h];
              mFull[h] = 0;
              mFull[h+1] = 1;
              mRun[h] = 0;
            end
          end
        end else if (mFullOld[h] && !mFullOld[h+1]) begin
          mRun[h] = 1;
          mCnt[h] = 0;
        end
      end
      if (bitTick) begin
        if (!mBusy) begin
          if (!rxLine) begin
            mBusy = 1; mPhase = 0; mAcc = 0;
            mDrop = mFullOld[0];
            mOvr = mFullOld[0];
          end
        end else begin
          if (mPhase < 7 && !mDrop) mAcc = mAcc | (int'(rxLine) << mPhase);
          if (mPhase == 6 && !mDrop) begin
            mVal[0] = mAcc;
            mFull[0] = 1;
          end
          if (mPhase == 8) begin
            mBusy = 0;
            mFerr = !rxLine;
          end else begin
            mPhase++;
          end
        end
      end
    end
  end

  // lockstep comparison, away from the active edge
  always @(negedge clk) begin
    if (rstN && !finished) begin
      check(codeValid == mFull[2], "R4 codeValid timing", int'(codeValid), int'(mFull[2]));
      if (mFull[2]) check(int'(entryCode) == mVal[2], "R6 entryCode", int'(entryCode), mVal[2]);
      check(overrun == mOvr, "R7 overrun pulse", int'(overrun), int'(mOvr));
      check(frameErr == mFerr, "R8 frameErr pulse", int'(frameErr), int'(mFerr));
      if (overrun) ovrSeen = 1;
      if (frameErr) ferrSeen = 1;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles == WATCHDOG && !finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, WATCHDOG);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic sendBit(input bit b);
    do @(posedge clk); while (!bitTick);
    @(negedge clk);
    rxLine = b;
  endtask

  task automatic sendFrame(input int code, input bit pad, input bit stopBit);
    sendBit(1'b0);
    for (int i = 0; i < 7; i++) sendBit(1'((code >> i) & 1));
    sendBit(pad);
    sendBit(stopBit);
    sendBit(1'b1);
  endtask

  task automatic waitBits(input int n);
    repeat (n * BIT_DIV) @(negedge clk);
  endtask

  task automatic checkDelivered(input string req);
    check(gotQ.size() == expQ.size(), req, gotQ.size(), expQ.size());
    for (int i = 0; i < expQ.size() && i < gotQ.size(); i++)
      check(gotQ[i] == expQ[i], req, gotQ[i], expQ[i]);
    gotQ.delete();
    expQ.delete();
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R9: clean state after reset
    check(!codeValid && !overrun && !frameErr, "R9 reset state",
          int'({codeValid, overrun, frameErr}), 0);

    // R1 / R2: two characters with the slot open, bit order checked
    sendFrame(7'h0B, 1'b1, 1'b1);
    sendFrame(7'h61, 1'b1, 1'b1);
    waitBits(2);
    expQ = '{7'h0B, 7'h61};
    checkDelivered("R2 LSB-first codes in order");

    // R5 / R1: fill all three stages with the slot closed
    @(negedge clk);
    slotReady = 1'b0;
    sendFrame(7'h13, 1'b1, 1'b1);
    sendFrame(7'h26, 1'b1, 1'b1);
    sendFrame(7'h4C, 1'b1, 1'b1);
    waitBits(1);
    check(codeValid == 1'b1, "R5 tail full while held", int'(codeValid), 1);
    check(int'(entryCode) == 7'h13, "R1 oldest code at output", int'(entryCode), 7'h13);
    waitBits(1);
    check(int'(entryCode) == 7'h13, "R6 code stable without slot", int'(entryCode), 7'h13);
    check(gotQ.size() == 0, "R6 nothing taken without slot", gotQ.size(), 0);

    // R7: fourth character while everything is full
    ovrSeen = 0;
    sendFrame(7'h7E, 1'b1, 1'b1);
    check(ovrSeen == 1'b1, "R7 overrun flagged", int'(ovrSeen), 1);
    @(negedge clk);
    slotReady = 1'b1;
    waitBits(2);
    expQ = '{7'h13, 7'h26, 7'h4C};
    checkDelivered("R7 dropped character absent, R1 order kept");

    // R8: missing stop bit flagged, character kept
    ferrSeen = 0;
    sendFrame(7'h35, 1'b1, 1'b0);
    waitBits(2);
    check(ferrSeen == 1'b1, "R8 framing error flagged", int'(ferrSeen), 1);
    expQ = '{7'h35};
    checkDelivered("R8 character kept after framing error");

    // R3: pad bit low has no effect
    sendFrame(7'h5A, 1'b0, 1'b1);
    sendFrame(7'h5A, 1'b1, 1'b1);
    waitBits(2);
    expQ = '{7'h5A, 7'h5A};
    checkDelivered("R3 pad bit ignored");

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule